// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Queue

This block is the waiting room between decode and execution in an out-of-order core. Decoded instructions are written in one per cycle, each with a sequence number, an instruction class, a source tag it waits on (or an already-ready flag) and a flag that marks it as non-speculative. Every cycle the queue chooses up to `ISSUE_N` entries that are ready. Older entries (smaller sequence numbers) are chosen first. Each class has its own issue limit. The chosen entries leave on registered issue ports, with the oldest on port 0.

A result broadcast on the wakeup port marks every resident entry that waits on that tag as ready. Non-speculative entries stay parked, even when ready, until the commit side names their exact sequence number. A squash input names a sequence number and discards every younger entry in one cycle. The insert side sees a registered free-entry count and a full flag.

Top module: `iq_issue_queue`

## Requirements
- R1: After reset no entry is valid. `free_cnt_o` equals DEPTH (8), `full_o` is 0 and no issue port is valid.
- R2: An insert is accepted only when a slot is free as of the current cycle and no squash is present. Otherwise it is dropped. `free_cnt_o` and `full_o` show the occupancy after each clock edge, and `full_o` is 1 exactly when `free_cnt_o` is 0.
- R3: An entry is eligible when it is valid, ready and not parked. Selection repeatedly takes the eligible entry with the smallest sequence number whose class still has room. Port k carries the k-th pick, so valid ports form a prefix in increasing sequence order.
- R4: Class codes are 0 integer, 1 floating point, 2 branch, 3 memory and 4 miscellaneous. Per cycle at most 2 integer entries issue, and at most 1 entry of each other class.
- R5: No more than ISSUE_N (3) entries issue in one cycle, across all classes.
- R6: An entry that is eligible at a clock edge and is picked appears on the issue ports right after that edge. Its slot is freed at the same edge.
- R7: An entry inserted with the non-speculative flag never issues until a commit carries its sequence number. After that it is eligible from the next edge on.
- R8: A commit whose sequence number matches no parked entry changes nothing.
- R9: An insert with the ready flag set is ready at once. A wakeup tag marks ready all resident valid entries that wait on that tag. Entries waiting on other tags are not affected, and neither is an entry being inserted at that same edge.
- R10: A squash removes every entry whose sequence number is greater than the squash number and keeps the rest. In the squash cycle nothing issues and no insert is accepted.
- R11: A slot freed by issue or squash at one edge can take an insert at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid_i | input | 1 | Insert request |
| ins_seq_i | input | SEQ_W | Sequence number of the new entry |
| ins_cls_i | input | 3 | Class code of the new entry |
| ins_ready_i | input | 1 | New entry's operands are already available |
| ins_tag_i | input | TAG_W | Tag the new entry waits on when not ready |
| ins_nonspec_i | input | 1 | New entry must wait for a commit release |
| free_cnt_o | output | clog2(DEPTH+1) | Number of empty slots |
| full_o | output | 1 | No empty slot |
| wake_valid_i | input | 1 | Wakeup broadcast valid |
| wake_tag_i | input | TAG_W | Tag being produced |
| commit_valid_i | input | 1 | Commit release valid |
| commit_seq_i | input | SEQ_W | Sequence number to release |
| squash_valid_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Entries younger than this are removed |
| iss_valid_o | output | ISSUE_N | Per-port issue valid |
| iss_seq_o | output | ISSUE_N*SEQ_W | Per-port sequence number, port 0 in the low bits |
| iss_cls_o | output | ISSUE_N*3 | Per-port class code, port 0 in the low bits |

## Verification
A full queue of one class that becomes ready all at once shows whether the per-class limit throttles issue and whether slots freed by issue are refilled on the next cycle. A batch of eight mixed-class entries woken together shows the difference between a class limit and the total limit, because a third integer entry must give way to a younger floating-point one. Entries inserted out of sequence order show whether age is decided by sequence number rather than by slot or arrival. Parked entries with mismatched and matching commits, and a squash that hits the middle of a group while an insert is attempted, cover the release and flush paths.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int NCLS  = 5;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT  = 3'd0,
    CLS_FP   = 3'd1,
    CLS_BR   = 3'd2,
    CLS_MEM  = 3'd3,
    CLS_MISC = 3'd4
  } iq_cls_e;
endpackage

// File: rtl/iq_age_pick.sv
// Finds the candidate with the smallest sequence number.
module iq_age_pick #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]            cand,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq,
  output logic                        found,
  output logic [IDX_W-1:0]            idx
);
  logic [SEQ_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i] && (!found || seq[i] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = seq[i];
      end
    end
  end
endmodule

// File: rtl/iq_slot_find.sv
// Lowest-index empty slot.
module iq_slot_find #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] busy,
  output logic             any_free,
  output logic [IDX_W-1:0] slot
);
  always_comb begin
    any_free = 1'b0;
    slot     = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        slot     = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/iq_issue_queue.sv
module iq_issue_queue
  import iq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int SEQ_W   = 16,
  parameter int TAG_W   = 5,
  parameter int ISSUE_N = 3,
  parameter int CAP_W   = 3,
  // per-class issue limit, class 0 in the low field
  parameter logic [NCLS*CAP_W-1:0] CLS_CAP = {3'd1, 3'd1, 3'd1, 3'd1, 3'd2},
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ins_valid_i,
  input  logic [SEQ_W-1:0]         ins_seq_i,
  input  logic [CLS_W-1:0]         ins_cls_i,
  input  logic                     ins_ready_i,
  input  logic [TAG_W-1:0]         ins_tag_i,
  input  logic                     ins_nonspec_i,
  output logic [CNT_W-1:0]         free_cnt_o,
  output logic                     full_o,
  input  logic                     wake_valid_i,
  input  logic [TAG_W-1:0]         wake_tag_i,
  input  logic                     commit_valid_i,
  input  logic [SEQ_W-1:0]         commit_seq_i,
  input  logic                     squash_valid_i,
  input  logic [SEQ_W-1:0]         squash_seq_i,
  output logic [ISSUE_N-1:0]       iss_valid_o,
  output logic [ISSUE_N*SEQ_W-1:0] iss_seq_o,
  output logic [ISSUE_N*CLS_W-1:0] iss_cls_o
);

  // entry state
  logic [DEPTH-1:0]            vld;
  logic [DEPTH-1:0]            rdy_r;
  logic [DEPTH-1:0]            hold_r;
  logic [DEPTH-1:0][SEQ_W-1:0] seq_r;
  logic [DEPTH-1:0][CLS_W-1:0] cls_r;
  logic [DEPTH-1:0][TAG_W-1:0] tag_r;

  function automatic logic [CAP_W-1:0] cap_of(input logic [CLS_W-1:0] c);
    cap_of = '0;
    for (int j = 0; j < NCLS; j++)
      if (c == CLS_W'(j)) cap_of = CLS_CAP[j*CAP_W +: CAP_W];
  endfunction

  function automatic logic [CAP_W-1:0] cnt_of(input logic [NCLS*CAP_W-1:0] cc,
                                              input logic [CLS_W-1:0] c);
    cnt_of = '0;
    for (int j = 0; j < NCLS; j++)
      if (c == CLS_W'(j)) cnt_of = cc[j*CAP_W +: CAP_W];
  endfunction

  // selection chain: one oldest-first pick per port
  logic [DEPTH-1:0]       avail [ISSUE_N+1];
  logic [NCLS*CAP_W-1:0]  ccnt  [ISSUE_N+1];
  logic                   pick_v   [ISSUE_N];
  logic [IDX_W-1:0]       pick_idx [ISSUE_N];

  assign avail[0] = (vld & rdy_r & ~hold_r) & {DEPTH{!squash_valid_i}};
  assign ccnt[0]  = '0;

  for (genvar k = 0; k < ISSUE_N; k++) begin : g_pick
    logic [DEPTH-1:0]      cand;
    logic                  found;
    logic [IDX_W-1:0]      idx;
    logic [DEPTH-1:0]      a_nxt;
    logic [NCLS*CAP_W-1:0] c_nxt;

    always_comb begin
      for (int i = 0; i < DEPTH; i++)
        cand[i] = avail[k][i] && (cnt_of(ccnt[k], cls_r[i]) < cap_of(cls_r[i]));
    end

    iq_age_pick #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_pick (
      .cand (cand),
      .seq  (seq_r),
      .found(found),
      .idx  (idx)
    );

    always_comb begin
      a_nxt = avail[k];
      c_nxt = ccnt[k];
      if (found) begin
        a_nxt[idx] = 1'b0;
        for (int j = 0; j < NCLS; j++)
          if (cls_r[idx] == CLS_W'(j))
            c_nxt[j*CAP_W +: CAP_W] = c_nxt[j*CAP_W +: CAP_W] + 1'b1;
      end
    end

    assign avail[k+1]  = a_nxt;
    assign ccnt[k+1]   = c_nxt;
    assign pick_v[k]   = found;
    assign pick_idx[k] = idx;
  end

  logic [DEPTH-1:0] iss_hit;
  always_comb begin
    iss_hit = '0;
    for (int k = 0; k < ISSUE_N; k++)
      if (pick_v[k]) iss_hit[pick_idx[k]] = 1'b1;
  end

  // insert slot from current occupancy
  logic             any_free;
  logic [IDX_W-1:0] ins_slot;
  logic             ins_we;

  iq_slot_find #(.DEPTH(DEPTH)) u_slot (
    .busy    (vld),
    .any_free(any_free),
    .slot    (ins_slot)
  );

  assign ins_we = ins_valid_i && !squash_valid_i && any_free;

  logic [DEPTH-1:0] vld_nxt;
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      vld_nxt[i] = vld[i];
      if (squash_valid_i && seq_r[i] > squash_seq_i) vld_nxt[i] = 1'b0;
      if (iss_hit[i]) vld_nxt[i] = 1'b0;
      if (ins_we && ins_slot == IDX_W'(i)) vld_nxt[i] = 1'b1;
    end
  end

  // entry payload: no reset needed, gated by vld
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wake_valid_i && vld[i] && tag_r[i] == wake_tag_i) rdy_r[i] <= 1'b1;
      if (commit_valid_i && vld[i] && seq_r[i] == commit_seq_i) hold_r[i] <= 1'b0;
      if (ins_we && ins_slot == IDX_W'(i)) begin
        seq_r[i]  <= ins_seq_i;
        cls_r[i]  <= ins_cls_i;
        tag_r[i]  <= ins_tag_i;
        rdy_r[i]  <= ins_ready_i;
        hold_r[i] <= ins_nonspec_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld        <= '0;
      free_cnt_o <= CNT_W'(DEPTH);
      full_o     <= 1'b0;
      iss_valid_o <= '0;
      iss_seq_o  <= '0;
      iss_cls_o  <= '0;
    end else begin
      vld        <= vld_nxt;
      free_cnt_o <= CNT_W'(DEPTH) - CNT_W'($countones(vld_nxt));
      full_o     <= &vld_nxt;
      for (int k = 0; k < ISSUE_N; k++) begin
        iss_valid_o[k]                 <= pick_v[k];
        iss_seq_o[k*SEQ_W +: SEQ_W]    <= seq_r[pick_idx[k]];
        iss_cls_o[k*CLS_W +: CLS_W]    <= cls_r[pick_idx[k]];
      end
    end
  end

  // ---------------- assertions ----------------
  for (genvar k = 0; k + 1 < ISSUE_N; k++) begin : g_ord
    p_port_order_r3: assert property (@(posedge clk) disable iff (rst)
      iss_valid_o[k+1] |-> (iss_valid_o[k] &&
        iss_seq_o[k*SEQ_W +: SEQ_W] < iss_seq_o[(k+1)*SEQ_W +: SEQ_W]));
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cap
    logic [ISSUE_N-1:0] same_cls;
    always_comb begin
      for (int k = 0; k < ISSUE_N; k++)
        same_cls[k] = iss_valid_o[k] && (iss_cls_o[k*CLS_W +: CLS_W] == CLS_W'(c));
    end
    p_class_cap_r4: assert property (@(posedge clk) disable iff (rst)
      $countones(same_cls) <= int'(CLS_CAP[c*CAP_W +: CAP_W]));
  end

  p_squash_no_issue_r10: assert property (@(posedge clk) disable iff (rst)
    squash_valid_i |=> (iss_valid_o == '0));

  p_squash_no_insert_r10: assert property (@(posedge clk) disable iff (rst)
    squash_valid_i |=> (free_cnt_o >= $past(free_cnt_o)));

  p_full_flag_r2: assert property (@(posedge clk) disable iff (rst)
    full_o |-> $past(ins_valid_i) || $past(full_o) || !$stable(free_cnt_o) || (free_cnt_o == '0));

endmodule

// File: tb/sim_iq_issue_queue.sv
module sim_iq_issue_queue;
  localparam int DEPTH = 8;
  localparam int NP    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        ins_valid, ins_ready, ins_ns;
  logic [15:0] ins_seq;
  logic [2:0]  ins_cls;
  logic [4:0]  ins_tag;
  logic [3:0]  free_cnt;
  logic        full;
  logic        wake_v;
  logic [4:0]  wake_tag;
  logic        com_v;
  logic [15:0] com_seq;
  logic        sq_v;
  logic [15:0] sq_seq;
  logic [NP-1:0]    iss_v;
  logic [NP*16-1:0] iss_seq;
  logic [NP*3-1:0]  iss_cls;

  iq_issue_queue u0 (
    .clk(clk), .rst(rst),
    .ins_valid_i(ins_valid), .ins_seq_i(ins_seq), .ins_cls_i(ins_cls),
    .ins_ready_i(ins_ready), .ins_tag_i(ins_tag), .ins_nonspec_i(ins_ns),
    .free_cnt_o(free_cnt), .full_o(full),
    .wake_valid_i(wake_v), .wake_tag_i(wake_tag),
    .commit_valid_i(com_v), .commit_seq_i(com_seq),
    .squash_valid_i(sq_v), .squash_seq_i(sq_seq),
    .iss_valid_o(iss_v), .iss_seq_o(iss_seq), .iss_cls_o(iss_cls)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit chk_en = 0;
  bit done = 0;
  int cyc = 0;

  // ---------- behavioural reference ----------
  typedef struct {int seq; int cls; int tag; bit rdy; bit hold;} ment_t;
  ment_t mq[$];
  ment_t nq[$];
  ment_t e;
  int caps[5] = '{2, 1, 1, 1, 1};
  int exp_v[NP], exp_seq[NP], exp_cls[NP];
  int exp_free = DEPTH;
  bit exp_full = 0;
  bit tk[DEPTH];
  int cc[5];
  int n0, best;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      for (int k = 0; k < NP; k++) exp_v[k] = 0;
      exp_free = DEPTH;
      exp_full = 0;
    end else begin
      n0 = mq.size();
      for (int j = 0; j < DEPTH; j++) tk[j] = 0;
      for (int c = 0; c < 5; c++) cc[c] = 0;
      for (int k = 0; k < NP; k++) begin
        exp_v[k] = 0;
        if (!sq_v) begin
          best = -1;
          for (int j = 0; j < n0; j++)
            if (!tk[j] && mq[j].rdy && !mq[j].hold && cc[mq[j].cls] < caps[mq[j].cls] &&
                (best < 0 || mq[j].seq < mq[best].seq)) best = j;
          if (best >= 0) begin
            tk[best] = 1;
            cc[mq[best].cls]++;
            exp_v[k] = 1;
            exp_seq[k] = mq[best].seq;
            exp_cls[k] = mq[best].cls;
          end
        end
      end
      nq.delete();
      for (int j = 0; j < n0; j++) begin
        if (tk[j]) continue;
        if (sq_v && mq[j].seq > int'(sq_seq)) continue;
        e = mq[j];
        if (wake_v && e.tag == int'(wake_tag)) e.rdy = 1;
        if (com_v && e.seq == int'(com_seq)) e.hold = 0;
        nq.push_back(e);
      end
      if (ins_valid && !sq_v && n0 < DEPTH) begin
        e.seq = int'(ins_seq); e.cls = int'(ins_cls); e.tag = int'(ins_tag);
        e.rdy = ins_ready; e.hold = ins_ns;
        nq.push_back(e);
      end
      mq = nq;
      exp_free = DEPTH - mq.size();
      exp_full = (mq.size() == DEPTH);
    end
  end

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (chk_en && !done) begin
      check(cur_req, "free_cnt", int'(free_cnt), exp_free);
      check(cur_req, "full", int'(full), int'(exp_full));
      for (int k = 0; k < NP; k++) begin
        check(cur_req, $sformatf("iss_valid[%0d]", k), int'(iss_v[k]), exp_v[k]);
        if (exp_v[k] != 0) begin
          check(cur_req, $sformatf("iss_seq[%0d]", k), int'(iss_seq[k*16 +: 16]), exp_seq[k]);
          check(cur_req, $sformatf("iss_cls[%0d]", k), int'(iss_cls[k*3 +: 3]), exp_cls[k]);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  // ---------- stimulus ----------
  task automatic clr();
    ins_valid = 0; ins_seq = '0; ins_cls = '0; ins_ready = 0; ins_tag = '0; ins_ns = 0;
    wake_v = 0; wake_tag = '0; com_v = 0; com_seq = '0; sq_v = 0; sq_seq = '0;
  endtask

  task automatic ins(int s, int c, bit r, int t, bit ns);
    @(negedge clk); clr();
    ins_valid = 1; ins_seq = 16'(s); ins_cls = 3'(c); ins_ready = r;
    ins_tag = 5'(t); ins_ns = ns;
  endtask

  task automatic wake(int t);
    @(negedge clk); clr(); wake_v = 1; wake_tag = 5'(t);
  endtask

  task automatic commit(int s);
    @(negedge clk); clr(); com_v = 1; com_seq = 16'(s);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); clr(); end
  endtask

  initial begin
    clr();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    chk_en = 1;
    // R1: reset state
    check("R1", "free_cnt after reset", int'(free_cnt), DEPTH);
    check("R1", "full after reset", int'(full), 0);
    check("R1", "no issue after reset", int'(iss_v), 0);
    idle(2);

    // R2: fill with waiting integer entries, then an insert while full
    cur_req = "R2";
    for (int s = 1; s <= 8; s++) ins(s, 0, 0, 1, 0);
    ins(9, 0, 0, 1, 0);
    idle(2);

    // R4 + R11: mass wakeup of integers, refill freed slots right away
    cur_req = "R4";
    wake(1);
    cur_req = "R11";
    ins(10, 1, 1, 0, 0);
    ins(11, 2, 1, 0, 0);
    ins(12, 0, 1, 0, 0);
    idle(6);

    // R5: mixed classes woken together
    cur_req = "R5";
    ins(20, 0, 0, 2, 0); ins(21, 0, 0, 2, 0); ins(22, 0, 0, 2, 0);
    ins(23, 1, 0, 2, 0); ins(24, 1, 0, 2, 0); ins(25, 2, 0, 2, 0);
    ins(26, 3, 0, 2, 0); ins(27, 4, 0, 2, 0);
    wake(2);
    idle(5);

    // R3: age by sequence number, not by arrival order
    cur_req = "R3";
    ins(50, 0, 0, 3, 0); ins(40, 1, 0, 3, 0); ins(45, 2, 0, 3, 0);
    wake(3);
    idle(3);

    // R6: a ready insert leaves right after the next edge
    cur_req = "R6";
    ins(60, 3, 1, 0, 0);
    idle(3);

    // R9: wakeup with a non-matching tag, then the right tag
    cur_req = "R9";
    ins(70, 0, 0, 5, 0);
    wake(6);
    idle(2);
    wake(5);
    idle(2);

    // R8 / R7: parked entry, wrong commit, right commit
    cur_req = "R8";
    ins(100, 0, 1, 0, 1);
    ins(101, 0, 1, 0, 0);
    idle(3);
    commit(99);
    idle(3);
    cur_req = "R7";
    commit(100);
    idle(3);

    // R10: squash in the middle of a group with an insert in the same cycle
    cur_req = "R10";
    for (int s = 200; s <= 205; s++) ins(s, 0, 0, 4, 0);
    @(negedge clk); clr();
    sq_v = 1; sq_seq = 16'd202;
    ins_valid = 1; ins_seq = 16'd206; ins_ready = 1;
    idle(2);
    wake(4);
    idle(4);
    // squash while ready entries would issue
    ins(300, 1, 0, 7, 0); ins(301, 2, 0, 7, 0);
    wake(7);
    @(negedge clk); clr(); sq_v = 1; sq_seq = 16'd300;
    idle(4);

    finish_run();
  end
endmodule